// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the host-side register file of a four-channel DMA controller. A processor reaches it over a narrow I/O bus with a 4-bit port number, separate write and read strobes, and byte-wide data in each direction. Each channel has a 16-bit transfer address and a 16-bit transfer count. Each of these sits behind one byte-wide port, so software moves it as two consecutive bytes. A single shared byte pointer decides whether an access hits the low or the high byte.

The remaining ports each hold one control function: the controller-wide command, per-channel mode, a software request, per-channel masking (one channel or all channels at once), pointer clearing and a master reset. The block exports the per-channel mode, mask, software request, address and count, along with a global enable, to the transfer engine that sits beside it. It takes back per-channel terminal-count pulses and hardware request levels, and software reads both through the status port.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the global enable is 1, the status byte reads 0 (with no hardware requests), the byte pointer selects the low byte, and all mode, request, address and count fields are 0.
- R2: Ports 0, 2, 4 and 6 hold the address of channels 0 to 3. A write stores the byte selected by the pointer (low byte when the pointer is clear). A read returns that byte. The stored value appears on `ch_addr[16*i+15:16*i]`.
- R3: Ports 1, 3, 5 and 7 hold the count of channels 0 to 3 in the same way, exported on `ch_count[16*i+15:16*i]`. Channels do not disturb each other.
- R4: The byte pointer flips after every read or write of ports 0 to 7, whichever channel is addressed. A write of any value to port 12 clears it.
- R5: A write to port 11 (mode) selects the channel with data bits 1:0 and stores data bits 7:2 as that channel's 6-bit mode, exported on `ch_mode[6*i+5:6*i]`.
- R6: A write to port 10 selects a channel with data bits 1:0 and sets that channel's mask bit to data bit 2 (1 masks).
- R7: A write to port 15 loads the four mask bits from data bits 3:0. A write to port 14 clears all four.
- R8: A write to port 13 (master reset) clears the byte pointer and the terminal-count flags and sets all four mask bits. Addresses, counts and modes are kept.
- R9: A write to port 8 stores the command byte. `ctrl_enable` is the inverse of command bit 2.
- R10: A read of port 8 returns terminal-count flags in bits 3:0 and request-pending flags (hardware OR software request) in bits 7:4. A `tc_in` pulse sets its flag until the next status read or master reset, and that read clears the flags. A pulse in the same cycle as the clear still leaves its flag set.
- R11: A write to port 9 selects a channel with data bits 1:0 and sets that channel's software request to data bit 2. The request is exported on `ch_swreq`.
- R12: Reads of ports 9 to 15 return 0. When both strobes are high, the access counts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port number |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| tc_in | input | 4 | Terminal-count pulse per channel |
| hw_req | input | 4 | Hardware request level per channel |
| ch_mode | output | 24 | Per-channel 6-bit mode |
| ch_mask | output | 4 | Per-channel mask |
| ch_swreq | output | 4 | Per-channel software request |
| ctrl_enable | output | 1 | Controller enabled |
| ch_addr | output | 64 | Per-channel 16-bit address |
| ch_count | output | 64 | Per-channel 16-bit count |

## Verification
Directed sequences program one channel with a low-then-high byte pair and read it back. This separates correct pointer sequencing from swapped or duplicated bytes. A second sequence interleaves accesses to different channels' ports to show that the pointer is shared and not held per channel. Terminal-count pulses are placed on the same cycle as a status read and on the cycle before it, which tells the read-clear apart from the sticky capture. A long random mix of all sixteen ports, with random data and request levels, is compared against a bench model after every access. This exposes mask, mode and request fields that are decoded from the wrong data bits.

// File: rtl/dmac_regfile.sv
module dmac_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  tc_in,
  input  logic [3:0]  hw_req,
  output logic [23:0] ch_mode,
  output logic [3:0]  ch_mask,
  output logic [3:0]  ch_swreq,
  output logic        ctrl_enable,
  output logic [63:0] ch_addr,
  output logic [63:0] ch_count
);
  localparam int NCH = 4;
  localparam int MW  = 6;
  localparam int WW  = 16;

  localparam logic [3:0] P_CMD   = 4'h8;
  localparam logic [3:0] P_REQ   = 4'h9;
  localparam logic [3:0] P_SMASK = 4'hA;
  localparam logic [3:0] P_MODE  = 4'hB;
  localparam logic [3:0] P_CLRFF = 4'hC;
  localparam logic [3:0] P_MRST  = 4'hD;
  localparam logic [3:0] P_CLRM  = 4'hE;
  localparam logic [3:0] P_ALLM  = 4'hF;

  logic [WW-1:0] addr_q [NCH];
  logic [WW-1:0] cnt_q  [NCH];
  logic [MW-1:0] mode_q [NCH];
  logic [NCH-1:0] mask_q, swreq_q, tc_q;
  logic [7:0] cmd_q;
  logic ptr_hi;

  wire wr        = io_wr;
  wire rd        = io_rd & ~io_wr;
  wire chan_port = ~io_addr[3];
  wire [1:0] psel = io_addr[2:1];
  wire [1:0] dsel = io_wdata[1:0];
  wire stat_rd   = rd && (io_addr == P_CMD);
  wire mrst      = wr && (io_addr == P_MRST);

  wire [WW-1:0] sel_word = io_addr[0] ? cnt_q[psel] : addr_q[psel];

  always_comb begin
    io_rdata = 8'h00;
    if (rd) begin
      if (chan_port)
        io_rdata = ptr_hi ? sel_word[15:8] : sel_word[7:0];
      else if (io_addr == P_CMD)
        io_rdata = {hw_req | swreq_q, tc_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi  <= 1'b0;
      tc_q    <= '0;
      mask_q  <= '1;
      swreq_q <= '0;
      cmd_q   <= '0;
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        mode_q[i] <= '0;
      end
    end else begin
      if ((wr || rd) && chan_port)
        ptr_hi <= ~ptr_hi;
      else if (wr && (io_addr == P_CLRFF || io_addr == P_MRST))
        ptr_hi <= 1'b0;

      tc_q <= ((stat_rd || mrst) ? '0 : tc_q) | tc_in;

      if (wr && chan_port) begin
        for (int i = 0; i < NCH; i++) begin
          if (psel == i[1:0]) begin
            if (io_addr[0]) begin
              if (ptr_hi) cnt_q[i][15:8] <= io_wdata;
              else        cnt_q[i][7:0]  <= io_wdata;
            end else begin
              if (ptr_hi) addr_q[i][15:8] <= io_wdata;
              else        addr_q[i][7:0]  <= io_wdata;
            end
          end
        end
      end

      if (wr) begin
        case (io_addr)
          P_CMD:   cmd_q <= io_wdata;
          P_REQ:   swreq_q[dsel] <= io_wdata[2];
          P_SMASK: mask_q[dsel] <= io_wdata[2];
          P_MODE:  mode_q[dsel] <= io_wdata[7:2];
          P_MRST:  mask_q <= '1;
          P_CLRM:  mask_q <= '0;
          P_ALLM:  mask_q <= io_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  assign ch_mask     = mask_q;
  assign ch_swreq    = swreq_q;
  assign ctrl_enable = ~cmd_q[2];

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign ch_mode[MW*g +: MW]  = mode_q[g];
    assign ch_addr[WW*g +: WW]  = addr_q[g];
    assign ch_count[WW*g +: WW] = cnt_q[g];
  end
endmodule

// File: rtl/dmac_regfile_sva.sv
module dmac_regfile_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] io_addr,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_wdata,
  input logic [3:0] tc_in,
  input logic [3:0] ch_mask,
  input logic       ctrl_enable,
  input logic       ptr_hi,
  input logic [3:0] tc_q
);
  a_r4_ptr_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_wr || io_rd) && !io_addr[3]) |=> (ptr_hi != $past(ptr_hi)));

  a_r4_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hC) |=> !ptr_hi);

  a_r8_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hD) |=> (ch_mask == 4'hF && !ptr_hi && tc_q == $past(tc_in)));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hE) |=> (ch_mask == 4'h0));

  a_r7_load_all: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'hF) |=> (ch_mask == $past(io_wdata[3:0])));

  a_r9_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'h8) |=> (ctrl_enable == !$past(io_wdata[2])));

  a_r10_tc_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_in != 4'h0) |=> ((tc_q & $past(tc_in)) == $past(tc_in)));

  a_r10_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr == 4'h8 && tc_in == 4'h0) |=> (tc_q == 4'h0));
endmodule

bind dmac_regfile dmac_regfile_sva u_sva (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .tc_in(tc_in), .ch_mask(ch_mask),
  .ctrl_enable(ctrl_enable), .ptr_hi(ptr_hi), .tc_q(tc_q)
);

// File: tb/dmac_regfile_test.sv
module dmac_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic [3:0] tc_in = '0, hw_req = '0;
  logic [23:0] ch_mode;
  logic [3:0] ch_mask, ch_swreq;
  logic ctrl_enable;
  logic [63:0] ch_addr, ch_count;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dmac_regfile uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tc_in(tc_in), .hw_req(hw_req),
    .ch_mode(ch_mode), .ch_mask(ch_mask), .ch_swreq(ch_swreq),
    .ctrl_enable(ctrl_enable), .ch_addr(ch_addr), .ch_count(ch_count)
  );

  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_swreq, m_tc;
  logic [7:0]  m_cmd;
  logic        m_ptr;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [3:0] a);
    logic [15:0] w;
    if (!a[3]) begin
      w = a[0] ? m_cnt[a[2:1]] : m_addr[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 4'h8) return {hw_req | m_swreq, m_tc};
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_addr[i] = '0; m_cnt[i] = '0; m_mode[i] = '0;
    end
    m_mask = 4'hF; m_swreq = '0; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
  endtask

  task automatic chk_outs(string req);
    logic [23:0] em;
    logic [63:0] ea, ec;
    for (int i = 0; i < 4; i++) begin
      em[6*i +: 6] = m_mode[i];
      ea[16*i +: 16] = m_addr[i];
      ec[16*i +: 16] = m_cnt[i];
    end
    chk({req, " mask"}, 64'(ch_mask), 64'(m_mask));
    chk({req, " enable"}, 64'(ctrl_enable), 64'(!m_cmd[2]));
    chk({req, " swreq"}, 64'(ch_swreq), 64'(m_swreq));
    chk({req, " mode"}, 64'(ch_mode), 64'(em));
    chk({req, " addr"}, ch_addr, ea);
    chk({req, " count"}, ch_count, ec);
  endtask

  task automatic do_wr(logic [3:0] a, logic [7:0] d, logic [3:0] tcp = 4'h0);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1; tc_in = tcp;
    @(negedge clk);
    io_wr = 1'b0; tc_in = '0;
    if (!a[3]) begin
      if (a[0]) begin
        if (m_ptr) m_cnt[a[2:1]][15:8] = d; else m_cnt[a[2:1]][7:0] = d;
      end else begin
        if (m_ptr) m_addr[a[2:1]][15:8] = d; else m_addr[a[2:1]][7:0] = d;
      end
      m_ptr = ~m_ptr;
    end else begin
      case (a)
        4'h8: m_cmd = d;
        4'h9: m_swreq[d[1:0]] = d[2];
        4'hA: m_mask[d[1:0]] = d[2];
        4'hB: m_mode[d[1:0]] = d[7:2];
        4'hC: m_ptr = 1'b0;
        4'hD: begin m_ptr = 1'b0; m_tc = '0; m_mask = 4'hF; end
        4'hE: m_mask = '0;
        default: m_mask = d[3:0];
      endcase
    end
    m_tc = m_tc | tcp;
  endtask

  task automatic do_rd(logic [3:0] a, string req, logic [3:0] tcp = 4'h0);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1; tc_in = tcp;
    #1;
    chk(req, 64'(io_rdata), 64'(exp_read(a)));
    @(negedge clk);
    io_rd = 1'b0; tc_in = '0;
    if (!a[3]) m_ptr = ~m_ptr;
    if (a == 4'h8) m_tc = '0;
    m_tc = m_tc | tcp;
  endtask

  task automatic pulse_tc(logic [3:0] v);
    @(negedge clk);
    tc_in = v;
    @(negedge clk);
    tc_in = '0;
    m_tc = m_tc | v;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_outs("R1");
    do_rd(4'h8, "R1 status");
    do_rd(4'h0, "R1 pointer low");
    do_wr(4'hC, 8'h00);

    // R2 address low then high, readback
    do_wr(4'h2, 8'h34); do_wr(4'h2, 8'h12);
    chk("R2 ch1 addr", 64'(ch_addr[31:16]), 64'h1234);
    do_rd(4'h2, "R2 read low"); do_rd(4'h2, "R2 read high");

    // R3 count on channel 3, channel 1 untouched
    do_wr(4'h7, 8'hCD); do_wr(4'h7, 8'hAB);
    chk("R3 ch3 count", 64'(ch_count[63:48]), 64'hABCD);
    chk("R3 ch1 addr kept", 64'(ch_addr[31:16]), 64'h1234);

    // R4 shared pointer across channels, clear port
    do_wr(4'h0, 8'h11);
    do_rd(4'h5, "R4 shared pointer high byte");
    do_wr(4'h4, 8'h99);
    chk("R4 ch2 addr low after two accesses", 64'(ch_addr[39:32]), 64'h99);
    do_wr(4'h0, 8'h22);
    do_wr(4'hC, 8'hFF);
    do_rd(4'h0, "R4 cleared pointer reads low");
    chk_outs("R4");

    // R5 mode
    do_wr(4'hB, 8'hB6);
    chk("R5 ch2 mode", 64'(ch_mode[17:12]), 64'h2D);
    do_wr(4'hB, 8'h4B);
    chk_outs("R5");

    // R6 single mask
    do_wr(4'hA, 8'h01);
    chk("R6 unmask ch1", 64'(ch_mask), 64'hD);
    do_wr(4'hA, 8'hFD);
    chk("R6 remask ch1", 64'(ch_mask), 64'hF);

    // R7 all masks
    do_wr(4'hF, 8'hA5);
    chk("R7 load all", 64'(ch_mask), 64'h5);
    do_wr(4'hE, 8'hFF);
    chk("R7 clear all", 64'(ch_mask), 64'h0);

    // R9 command
    do_wr(4'h8, 8'h04);
    chk("R9 disabled", 64'(ctrl_enable), 64'h0);
    do_wr(4'h8, 8'hFB);
    chk("R9 enabled", 64'(ctrl_enable), 64'h1);

    // R11 software request
    do_wr(4'h9, 8'h06);
    chk("R11 swreq ch2", 64'(ch_swreq), 64'h4);

    // R10 status capture, read-clear, same-cycle pulse
    hw_req = 4'h2;
    pulse_tc(4'h5);
    do_rd(4'h8, "R10 status flags");
    do_rd(4'h8, "R10 cleared after read", 4'h8);
    do_rd(4'h8, "R10 pulse during read kept");
    hw_req = 4'h0;

    // R8 master reset
    do_wr(4'h1, 8'h77);
    pulse_tc(4'h3);
    do_wr(4'hD, 8'h00);
    chk_outs("R8");
    do_rd(4'h8, "R8 status cleared");
    do_rd(4'h1, "R8 pointer cleared");

    // R12 other ports read 0; both strobes act as write
    for (int p = 9; p < 16; p++) do_rd(4'(p), "R12 read zero");
    do_wr(4'hC, 8'h00);
    @(negedge clk);
    io_addr = 4'h6; io_wdata = 8'h5A; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    m_addr[3][7:0] = 8'h5A; m_ptr = 1'b1;
    chk_outs("R12 write wins");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      hw_req = 4'($urandom);
      case ($urandom_range(0, 3))
        0: do_rd(a, "R2 R3 R10 random read");
        1: pulse_tc(4'($urandom));
        default: do_wr(a, d);
      endcase
      if (n % 8 == 0) chk_outs("R5 R6 R7 R11 random");
    end
    hw_req = '0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule